// File: doc/BRIEF.md
# Indirect CSR Access Permission Checker

This block decides whether a CSR instruction aimed at one of the three indirect alias registers must trap. The three aliases are the machine alias, the supervisor alias and the virtual-supervisor alias. The decoder presents the target, the current privilege level, the virtualization flag, the three select registers, the supervisor external-interrupt delegation bit and the guest interrupt file selector. One clock edge later the block answers with a valid strobe and at most one of two exception flags: illegal instruction or virtual instruction.

The decision is made in two ordered stages. The first stage applies the ordinary permission rules, which depend on privilege and virtualization. Only when that stage raises nothing does the second stage look at the select value. The second stage sorts the select value into windows and also looks at its lowest bit and at the guest selector. Within a stage, illegal instruction wins over virtual instruction. A request whose target is not an alias register passes both stages and reports no exception.

Top module: `ind_csr_guard`

## Requirements
- R1: When `req_vld` was high at a rising edge, `rsp_vld` is high after that edge and at most one of `rsp_ill`/`rsp_vi` is high. When `req_vld` was low, all three outputs are low.
- R2: Stage one, machine alias target (`req_tgt`=1): any privilege other than M (`priv`=3) raises illegal instruction. Privilege codes are 0=U, 1=S, 3=M, and 2 is treated as U.
- R3: Stage one, supervisor alias target (`req_tgt`=2) from a privilege below S: virtual instruction if `virt` is high, otherwise illegal instruction. S and M pass.
- R4: Stage one, virtual-supervisor alias target (`req_tgt`=3): virtual instruction whenever `virt` is high and privilege is not M. Non-virtual U raises illegal instruction. Non-virtual S and M pass. `virt` is ignored in M.
- R5: A stage-one exception suppresses every stage-two result. For example, a virtualized U-mode access to the supervisor alias with a select of 0x00 reports virtual instruction only.
- R6: Machine alias, uses `msel`. It is illegal when the value is at or below 0x2F, in 0x40..0x6F, or above SEL_MAX. It is also illegal when the value is odd in 0x30..0x3F, or odd and above 0x7F up to SEL_MAX. All other values pass.
- R7: Supervisor alias with virtualization off, uses `ssel`. The same rules as R6 apply. In addition, any value in 0x70..SEL_MAX is illegal when `priv` is S and `s_deleg` is high.
- R8: Supervisor alias with virtualization on, uses `vssel`. It is illegal at or below 0x2F, in 0x40..0x6F, or above SEL_MAX. Any value in 0x30..0x3F raises virtual instruction. A value in 0x70..SEL_MAX raises virtual instruction when `guest_sel` is 0 or above GUEST_N, or when the value is above 0x7F and odd.
- R9: Virtual-supervisor alias, uses `vssel`. It is illegal at or below 0x6F or above SEL_MAX. In 0x70..SEL_MAX it is illegal when `guest_sel` is 0 or above GUEST_N, or when the value is above 0x7F and odd.
- R10: A request with `req_tgt`=0 (not an alias) reports no exception.
- R11: While `rst_n` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request strobe |
| req_tgt | input | 2 | Target: 0 none, 1 machine alias, 2 supervisor alias, 3 virtual-supervisor alias |
| priv | input | 2 | Privilege: 0 U, 1 S, 3 M (2 treated as U) |
| virt | input | 1 | Virtualization active |
| msel | input | SEL_W | Machine select register |
| ssel | input | SEL_W | Supervisor select register |
| vssel | input | SEL_W | Virtual-supervisor select register |
| s_deleg | input | 1 | Supervisor external interrupt delegation enable |
| guest_sel | input | GSEL_W | Guest interrupt file selector |
| rsp_vld | output | 1 | Response valid |
| rsp_ill | output | 1 | Illegal instruction |
| rsp_vi | output | 1 | Virtual instruction |

## Verification
Every result is due exactly one rising edge after the request is presented, because both stages are combinational and feed a single register. The bench changes inputs on the falling edge and reads the outputs on the next falling edge, half a cycle after the rising edge that captured them. Idle cycles are checked in the same slot, which confirms that the outputs return low. The reset check takes place while reset is held, and requests start only after the synchronized release has passed.

// File: rtl/ind_csr_pkg.sv
package ind_csr_pkg;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_MACH = 2'd1,
    TGT_SUP  = 2'd2,
    TGT_VSUP = 2'd3
  } tgt_e;

  typedef enum logic [2:0] {
    Z_LOW,   // at or below 0x2F
    Z_PAIR,  // 0x30..0x3F
    Z_GAP,   // 0x40..0x6F
    Z_FILE,  // 0x70..max
    Z_HIGH   // above max
  } zone_e;

  typedef struct packed {
    logic ill;
    logic vi;
  } exc_t;

  localparam int unsigned LIM_LOW  = 'h2F;
  localparam int unsigned LIM_PAIR = 'h3F;
  localparam int unsigned LIM_GAP  = 'h6F;
  localparam int unsigned LIM_UP   = 'h7F;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam exc_t EXC_NONE = '{ill: 1'b0, vi: 1'b0};

endpackage

// File: rtl/ind_csr_rst_sync.sv
module ind_csr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_sync_n = stg_q[1];
endmodule

// File: rtl/ind_csr_zone.sv
module ind_csr_zone
  import ind_csr_pkg::*;
#(
  parameter int SEL_W   = 12,
  parameter int SEL_MAX = 'hFF
) (
  input  logic [SEL_W-1:0] sel,
  output zone_e            zone,
  output logic             odd,
  output logic             upper
);
  localparam logic [SEL_W-1:0] B_LOW  = SEL_W'(LIM_LOW);
  localparam logic [SEL_W-1:0] B_PAIR = SEL_W'(LIM_PAIR);
  localparam logic [SEL_W-1:0] B_GAP  = SEL_W'(LIM_GAP);
  localparam logic [SEL_W-1:0] B_UP   = SEL_W'(LIM_UP);
  localparam logic [SEL_W-1:0] B_MAX  = SEL_W'(SEL_MAX);

  always_comb begin
    if (sel <= B_LOW)       zone = Z_LOW;
    else if (sel <= B_PAIR) zone = Z_PAIR;
    else if (sel <= B_GAP)  zone = Z_GAP;
    else if (sel <= B_MAX)  zone = Z_FILE;
    else                    zone = Z_HIGH;
    odd   = sel[0];
    upper = (sel > B_UP);
  end
endmodule

// File: rtl/ind_csr_base_chk.sv
module ind_csr_base_chk
  import ind_csr_pkg::*;
(
  input  tgt_e       tgt,
  input  logic [1:0] priv,
  input  logic       v_eff,
  output exc_t       exc
);
  logic is_m, is_s;

  always_comb begin
    is_m = (priv == PRIV_M);
    is_s = (priv == PRIV_S);
    exc  = EXC_NONE;
    unique case (tgt)
      TGT_MACH: exc.ill = !is_m;
      TGT_SUP: begin
        if (!is_m && !is_s) begin
          if (v_eff) exc.vi  = 1'b1;
          else       exc.ill = 1'b1;
        end
      end
      TGT_VSUP: begin
        if (v_eff)              exc.vi  = 1'b1;
        else if (!is_m && !is_s) exc.ill = 1'b1;
      end
      default: exc = EXC_NONE;
    endcase
  end
endmodule

// File: rtl/ind_csr_sel_chk.sv
module ind_csr_sel_chk
  import ind_csr_pkg::*;
#(
  parameter int GSEL_W  = 6,
  parameter int GUEST_N = 7
) (
  input  tgt_e              tgt,
  input  logic              is_s,
  input  logic              v_eff,
  input  logic              s_deleg,
  input  logic [GSEL_W-1:0] guest_sel,
  input  zone_e             z_m,
  input  logic              odd_m,
  input  logic              up_m,
  input  zone_e             z_s,
  input  logic              odd_s,
  input  logic              up_s,
  input  zone_e             z_v,
  input  logic              odd_v,
  input  logic              up_v,
  output exc_t              exc
);
  localparam logic [GSEL_W-1:0] G_LIM = GSEL_W'(GUEST_N);

  logic guest_bad;
  logic m_bad, s_bad, v_file_bad;

  always_comb begin
    guest_bad  = (guest_sel == '0) || (guest_sel > G_LIM);
    m_bad      = (z_m == Z_LOW) || (z_m == Z_GAP) || (z_m == Z_HIGH) ||
                 ((z_m == Z_PAIR) && odd_m) ||
                 ((z_m == Z_FILE) && up_m && odd_m);
    s_bad      = (z_s == Z_LOW) || (z_s == Z_GAP) || (z_s == Z_HIGH) ||
                 ((z_s == Z_PAIR) && odd_s) ||
                 ((z_s == Z_FILE) && ((up_s && odd_s) || (is_s && s_deleg)));
    v_file_bad = (z_v == Z_FILE) && (guest_bad || (up_v && odd_v));

    exc = EXC_NONE;
    unique case (tgt)
      TGT_MACH: exc.ill = m_bad;
      TGT_SUP: begin
        if (!v_eff) begin
          exc.ill = s_bad;
        end else begin
          exc.ill = (z_v == Z_LOW) || (z_v == Z_GAP) || (z_v == Z_HIGH);
          exc.vi  = !exc.ill && ((z_v == Z_PAIR) || v_file_bad);
        end
      end
      TGT_VSUP: exc.ill = (z_v != Z_FILE) || v_file_bad;
      default:  exc = EXC_NONE;
    endcase
  end
endmodule

// File: rtl/ind_csr_guard.sv
module ind_csr_guard
  import ind_csr_pkg::*;
#(
  parameter int SEL_W   = 12,
  parameter int SEL_MAX = 'hFF,
  parameter int GSEL_W  = 6,
  parameter int GUEST_N = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic [1:0]        req_tgt,
  input  logic [1:0]        priv,
  input  logic              virt,
  input  logic [SEL_W-1:0]  msel,
  input  logic [SEL_W-1:0]  ssel,
  input  logic [SEL_W-1:0]  vssel,
  input  logic              s_deleg,
  input  logic [GSEL_W-1:0] guest_sel,
  output logic              rsp_vld,
  output logic              rsp_ill,
  output logic              rsp_vi
);
  localparam int NSEL = 3;

  logic       rst_sync_n;
  tgt_e       tgt;
  logic       v_eff;
  logic       is_s;
  exc_t       exc_base, exc_sel, exc_fin;

  logic [SEL_W-1:0] sel_arr [NSEL];
  zone_e            zone_arr[NSEL];
  logic             odd_arr [NSEL];
  logic             up_arr  [NSEL];

  logic vld_d, ill_d, vi_d;
  logic vld_q, ill_q, vi_q;

  ind_csr_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  always_comb begin
    tgt        = tgt_e'(req_tgt);
    is_s       = (priv == PRIV_S);
    v_eff      = virt && (priv != PRIV_M);
    sel_arr[0] = msel;
    sel_arr[1] = ssel;
    sel_arr[2] = vssel;
  end

  for (genvar gi = 0; gi < NSEL; gi++) begin : g_zone
    ind_csr_zone #(.SEL_W(SEL_W), .SEL_MAX(SEL_MAX)) u_zone (
      .sel  (sel_arr[gi]),
      .zone (zone_arr[gi]),
      .odd  (odd_arr[gi]),
      .upper(up_arr[gi])
    );
  end

  ind_csr_base_chk u_base (
    .tgt  (tgt),
    .priv (priv),
    .v_eff(v_eff),
    .exc  (exc_base)
  );

  ind_csr_sel_chk #(.GSEL_W(GSEL_W), .GUEST_N(GUEST_N)) u_sel (
    .tgt      (tgt),
    .is_s     (is_s),
    .v_eff    (v_eff),
    .s_deleg  (s_deleg),
    .guest_sel(guest_sel),
    .z_m      (zone_arr[0]),
    .odd_m    (odd_arr[0]),
    .up_m     (up_arr[0]),
    .z_s      (zone_arr[1]),
    .odd_s    (odd_arr[1]),
    .up_s     (up_arr[1]),
    .z_v      (zone_arr[2]),
    .odd_v    (odd_arr[2]),
    .up_v     (up_arr[2]),
    .exc      (exc_sel)
  );

  // stage ordering: the second stage counts only when the first is clean
  always_comb begin
    if (exc_base.ill || exc_base.vi) exc_fin = exc_base;
    else                             exc_fin = exc_sel;
    vld_d = req_vld;
    ill_d = req_vld && exc_fin.ill;
    vi_d  = req_vld && !exc_fin.ill && exc_fin.vi;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
      ill_q <= 1'b0;
      vi_q  <= 1'b0;
    end else begin
      vld_q <= vld_d;
      ill_q <= ill_d;
      vi_q  <= vi_d;
    end
  end

  assign rsp_vld = vld_q;
  assign rsp_ill = ill_q;
  assign rsp_vi  = vi_q;
endmodule

// File: rtl/ind_csr_guard_chk.sv
module ind_csr_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_vld,
  input logic [1:0] req_tgt,
  input logic [1:0] priv,
  input logic       virt,
  input logic       rsp_vld,
  input logic       rsp_ill,
  input logic       rsp_vi
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_one_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_ill, rsp_vi}) && ((rsp_ill || rsp_vi) -> rsp_vld));

  assert_resp_timing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (rsp_vld == $past(req_vld)));

  assert_mach_priv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(req_vld && req_tgt == 2'd1 && priv != 2'd3)) |-> rsp_ill);

  assert_sup_user_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(req_vld && req_tgt == 2'd2 && (priv == 2'd0 || priv == 2'd2) && virt))
      |-> (rsp_vi && !rsp_ill));

  assert_vs_virt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(req_vld && req_tgt == 2'd3 && priv != 2'd3 && virt))
      |-> (rsp_vi && !rsp_ill));

  assert_none_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(req_vld && req_tgt == 2'd0)) |-> (!rsp_ill && !rsp_vi));
endmodule

bind ind_csr_guard ind_csr_guard_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .req_vld(req_vld),
  .req_tgt(req_tgt),
  .priv   (priv),
  .virt   (virt),
  .rsp_vld(rsp_vld),
  .rsp_ill(rsp_ill),
  .rsp_vi (rsp_vi)
);

// File: tb/ind_csr_guard_tb.sv
`timescale 1ns/1ps
module ind_csr_guard_tb;
  localparam int SEL_W   = 12;
  localparam int SEL_MAX = 'hFF;
  localparam int GSEL_W  = 6;
  localparam int GUEST_N = 7;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_vld;
  logic [1:0]        req_tgt;
  logic [1:0]        priv;
  logic              virt;
  logic [SEL_W-1:0]  msel, ssel, vssel;
  logic              s_deleg;
  logic [GSEL_W-1:0] guest_sel;
  logic              rsp_vld, rsp_ill, rsp_vi;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  ind_csr_guard #(.SEL_W(SEL_W), .SEL_MAX(SEL_MAX), .GSEL_W(GSEL_W), .GUEST_N(GUEST_N)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_tgt(req_tgt), .priv(priv),
    .virt(virt), .msel(msel), .ssel(ssel), .vssel(vssel), .s_deleg(s_deleg),
    .guest_sel(guest_sel), .rsp_vld(rsp_vld), .rsp_ill(rsp_ill), .rsp_vi(rsp_vi)
  );

  // window rule shared by machine and non-virtual supervisor paths
  function automatic bit plain_bad(int s);
    if (s <= 'h2F) return 1;
    if (s <= 'h3F) return s[0];
    if (s <= 'h6F) return 1;
    if (s <= SEL_MAX) return (s > 'h7F) && s[0];
    return 1;
  endfunction

  function automatic bit guest_off(int g, int s);
    return (g == 0) || (g > GUEST_N) || ((s > 'h7F) && s[0]);
  endfunction

  // returns {ill, vi}
  function automatic logic [1:0] expect_exc(int tg, int pv, bit vt, int ms, int ss,
                                            int vs, bit dl, int g);
    bit m  = (pv == 3);
    bit sm = (pv == 1);
    bit v  = vt && !m;
    // first stage
    if (tg == 1 && !m) return 2'b10;
    if (tg == 2 && !m && !sm) return v ? 2'b01 : 2'b10;
    if (tg == 3) begin
      if (v) return 2'b01;
      if (!m && !sm) return 2'b10;
    end
    // second stage
    case (tg)
      1: return {plain_bad(ms), 1'b0};
      2: begin
        if (!v) return {plain_bad(ss) || (ss >= 'h70 && ss <= SEL_MAX && sm && dl), 1'b0};
        if (vs <= 'h2F || (vs >= 'h40 && vs <= 'h6F) || vs > SEL_MAX) return 2'b10;
        if (vs <= 'h3F) return 2'b01;
        return {1'b0, guest_off(g, vs)};
      end
      3: begin
        if (vs <= 'h6F || vs > SEL_MAX) return 2'b10;
        return {guest_off(g, vs), 1'b0};
      end
      default: return 2'b00;
    endcase
  endfunction

  function automatic string tag_of(int tg, int pv, bit vt);
    bit m = (pv == 3);
    bit v = vt && !m;
    case (tg)
      0: return "R10";
      1: return m ? "R6" : "R2";
      2: return (!m && pv != 1) ? "R3" : (v ? "R8" : "R7");
      default: return (v || (!m && pv != 1)) ? "R4" : "R9";
    endcase
  endfunction

  task automatic check(string tag, logic ev, logic ei, logic eu);
    total++;
    if (rsp_vld !== ev || rsp_ill !== ei || rsp_vi !== eu) begin
      bad++;
      $display("FAIL %s: got vld=%b ill=%b vi=%b, want vld=%b ill=%b vi=%b (tgt=%0d priv=%0d virt=%b m=%h s=%h vs=%h dl=%b g=%0d)",
               tag, rsp_vld, rsp_ill, rsp_vi, ev, ei, eu,
               req_tgt, priv, virt, msel, ssel, vssel, s_deleg, guest_sel);
    end
  endtask

  // drive at falling edge, sample at next falling edge
  task automatic do_req(string tag, int tg, int pv, bit vt, int ms, int ss, int vs,
                        bit dl, int g);
    logic [1:0] e;
    req_vld = 1'b1; req_tgt = 2'(tg); priv = 2'(pv); virt = vt;
    msel = SEL_W'(ms); ssel = SEL_W'(ss); vssel = SEL_W'(vs);
    s_deleg = dl; guest_sel = GSEL_W'(g);
    e = expect_exc(tg, pv, vt, ms, ss, vs, dl, g);
    @(negedge clk);
    check(tag, 1'b1, e[1], e[0]);
  endtask

  task automatic do_idle();
    req_vld = 1'b0;
    req_tgt = 2'($urandom % 4);
    @(negedge clk);
    check("R1", 1'b0, 1'b0, 1'b0);
  endtask

  function automatic int pick_sel();
    int edges[16] = '{'h00, 'h2F, 'h30, 'h31, 'h3E, 'h3F, 'h40, 'h6F,
                      'h70, 'h71, 'h7F, 'h80, 'h81, 'hFE, 'hFF, 'h100};
    if ($urandom % 3 != 0) return edges[$urandom % 16];
    return int'($urandom % 'h140);
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got no end, want completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    rst_n = 1'b0; req_vld = 1'b1; req_tgt = 2'd1; priv = 2'd0; virt = 1'b0;
    msel = '0; ssel = '0; vssel = '0; s_deleg = 1'b0; guest_sel = '0;
    repeat (3) @(negedge clk);
    check("R11", 1'b0, 1'b0, 1'b0);
    req_vld = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", 1'b0, 1'b0, 1'b0);

    // machine alias window edges (R6), privilege failure (R2)
    do_req("R6", 1, 3, 0, 'h2F, 0, 0, 0, 1);
    do_req("R6", 1, 3, 0, 'h30, 0, 0, 0, 1);
    do_req("R6", 1, 3, 0, 'h31, 0, 0, 0, 1);
    do_req("R6", 1, 3, 0, 'h40, 0, 0, 0, 1);
    do_req("R6", 1, 3, 0, 'h70, 0, 0, 0, 1);
    do_req("R6", 1, 3, 0, 'h7F, 0, 0, 0, 1);
    do_req("R6", 1, 3, 0, 'h81, 0, 0, 0, 1);
    do_req("R6", 1, 3, 0, 'hFF, 0, 0, 0, 1);
    do_req("R6", 1, 3, 0, 'h100, 0, 0, 0, 1);
    do_req("R2", 1, 1, 0, 'h70, 0, 0, 0, 1);
    // supervisor alias non-virtual (R7)
    do_req("R7", 2, 1, 0, 0, 'h70, 0, 0, 1);
    do_req("R7", 2, 1, 0, 0, 'h70, 0, 1, 1);
    do_req("R7", 2, 3, 0, 0, 'h70, 0, 1, 1);
    do_req("R7", 2, 1, 0, 0, 'h3E, 0, 1, 1);
    // supervisor alias virtualized (R8)
    do_req("R8", 2, 1, 1, 0, 0, 'h30, 0, 1);
    do_req("R8", 2, 1, 1, 0, 0, 'h2F, 0, 1);
    do_req("R8", 2, 1, 1, 0, 0, 'h70, 0, 0);
    do_req("R8", 2, 1, 1, 0, 0, 'h70, 0, GUEST_N);
    do_req("R8", 2, 1, 1, 0, 0, 'h70, 0, GUEST_N + 1);
    do_req("R8", 2, 1, 1, 0, 0, 'h83, 0, 1);
    // virtual-supervisor alias (R9), stage-one cases (R3, R4)
    do_req("R9", 3, 1, 0, 0, 0, 'h3E, 0, 1);
    do_req("R9", 3, 1, 0, 0, 0, 'h72, 0, 2);
    do_req("R9", 3, 3, 1, 0, 0, 'h72, 0, 0);
    do_req("R4", 3, 1, 1, 0, 0, 'h72, 0, 2);
    do_req("R4", 3, 0, 0, 0, 0, 'h72, 0, 2);
    do_req("R3", 2, 0, 1, 0, 'h70, 'h70, 0, 1);
    do_req("R3", 2, 2, 0, 0, 'h70, 'h70, 0, 1);
    // ordering (R5): stage-one virtual wins over bad select
    do_req("R5", 2, 0, 1, 0, 0, 'h00, 0, 0);
    do_req("R5", 3, 0, 1, 0, 0, 'h00, 0, 0);
    do_req("R10", 0, 0, 1, 0, 0, 0, 0, 0);
    do_idle();

    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 8 == 0) do_idle();
      else begin
        int tg = int'($urandom % 4);
        int pv = int'($urandom % 4);
        bit vt = 1'($urandom);
        do_req(tag_of(tg, pv, vt), tg, pv, vt, pick_sel(), pick_sel(), pick_sel(),
               1'($urandom), int'($urandom % 10));
      end
    end
    do_idle();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule